// File: doc/BRIEF.md
# Ninth-Degree Polynomial Evaluator, Parallel Low-Latency Form

This block evaluates y = a0 + a1·x + a2·x² + … + a9·x⁹ on a stream of fixed-point samples. It accepts one sample on every clock and returns its result five clocks later. It does not use the nested multiply-add chain, whose delay grows with the degree. Instead it builds the powers of x by squaring: x² from x·x, x⁴ from x²·x², and x³ from x²·x. It forms every coefficient product alongside these powers. The deepest term, a9·x⁹, is built as (a9·x)·x⁴·x⁴. That term needs four multiply stages. One last stage adds all ten terms and clamps the sum.

Terms that finish early are held in delay registers, so that all nine product terms reach the final adder on the same clock. A valid bit moves through a five-deep shift register that matches the data path. Every product is truncated toward minus infinity. As a result the output differs from the exact polynomial by a small bounded amount. The coefficients are plain input ports that the user holds steady.

Top module: `poly9_eval`

## Requirements
- R1: The input x is two's complement with 7 fraction bits (value x/128, range −1 to 127/128). Coefficient ai sits in `coef[16i+15:16i]` as two's complement with 12 fraction bits. The output is two's complement with 12 fraction bits. The output lies within 64 LSB of the exact polynomial value clamped to the output range.
- R2: A sample taken with `in_valid` high at rising edge k appears on `y_out` with `out_valid` high after rising edge k+4, which is five registered stages.
- R3: One sample is accepted on every clock, with no stall. Results leave in input order, exactly one per accepted sample. `out_valid` is never high for any other reason.
- R4: A sum above 32767 LSB gives exactly 32767. A sum below −32768 LSB gives exactly −32768.
- R5: When x = 0, the output equals a0 exactly.
- R6: When x = −1.0 (code 0x80), the output equals a0 − a1 + a2 − … − a9 exactly, clamped as in R4.
- R7: Synchronous active-high reset clears `out_valid` and `y_out` to zero on the next edge. Samples in flight at reset never reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks x_in as a sample to evaluate |
| x_in | input | 8 | Sample, two's complement, 7 fraction bits |
| coef | input | 160 | Ten 16-bit coefficients; ai in bits [16i+15:16i] |
| out_valid | output | 1 | Marks y_out as a result |
| y_out | output | 16 | Result, two's complement, 12 fraction bits, saturated |

## Verification
The bench sweeps every one of the 256 input codes under two coefficient sets. One sweep runs back to back and one has gaps. A stage that skipped its delay register, or a power built one degree off, would land far outside the 64 LSB bound or come out a clock early or late. Exact checks at x = 0 and x = −1.0 expose any stray truncation on the paths where the arithmetic should be lossless, and any slip in term signs. Coefficients driven to full scale at x ≈ 1 push the sum far past the output range: a wrapping adder would return a wrong-signed value instead of the clamp. A reset applied while samples are in flight must leave no output behind, and the bench would see a leftover valid as an unexpected result.

// File: rtl/poly9_pkg.sv
package poly9_pkg;

    parameter int XW    = 8;
    parameter int CW    = 16;
    parameter int CF    = 12;
    parameter int YW    = 16;
    parameter int NCOEF = 10;
    parameter int LAT   = 5;

    localparam int XF = XW - 1;
    localparam int PF = 2 * XF;
    localparam int PW = PF + 2;
    localparam int TW = CW + 1;
    localparam int SW = TW + $clog2(NCOEF) + 1;

    typedef logic signed [XW-1:0] x_t;
    typedef logic signed [CW-1:0] coef_t;
    typedef logic signed [PW-1:0] pow_t;
    typedef logic signed [TW-1:0] term_t;
    typedef logic signed [SW-1:0] acc_t;
    typedef logic signed [YW-1:0] y_t;

    typedef term_t [NCOEF-1:1] term_bus_t;

    typedef struct packed {
        x_t   x;
        pow_t sq;
    } pw_s1_t;

    typedef struct packed {
        pow_t sq;
        pow_t cube;
        pow_t quad;
    } pw_s2_t;

    typedef struct packed {
        pow_t cube;
        pow_t quad;
    } pw_s3_t;

    function automatic pow_t pw_from_x(x_t x);
        logic signed [2*XW-1:0] p;
        p = (2*XW)'(x) * (2*XW)'(x);
        return pow_t'(p);
    endfunction

    function automatic pow_t pw_mul(pow_t a, pow_t b);
        logic signed [2*PW-1:0] p;
        p = (2*PW)'(a) * (2*PW)'(b);
        return pow_t'(p >>> PF);
    endfunction

    function automatic pow_t pw_mul_x(pow_t a, x_t x);
        logic signed [PW+XW-1:0] p;
        p = (PW+XW)'(a) * (PW+XW)'(x);
        return pow_t'(p >>> XF);
    endfunction

    function automatic term_t tm_coef_x(coef_t a, x_t x);
        logic signed [CW+XW-1:0] p;
        p = (CW+XW)'(a) * (CW+XW)'(x);
        return term_t'(p >>> XF);
    endfunction

    function automatic term_t tm_pow(term_t t, pow_t q);
        logic signed [TW+PW-1:0] p;
        p = (TW+PW)'(t) * (TW+PW)'(q);
        return term_t'(p >>> PF);
    endfunction

    function automatic term_t tm_x(term_t t, x_t x);
        logic signed [TW+XW-1:0] p;
        p = (TW+XW)'(t) * (TW+XW)'(x);
        return term_t'(p >>> XF);
    endfunction

    function automatic y_t sat_y(acc_t s);
        acc_t hi;
        acc_t lo;
        hi = {{(SW-YW+1){1'b0}}, {(YW-1){1'b1}}};
        lo = ~hi;
        if (s > hi)      return y_t'(hi);
        else if (s < lo) return y_t'(lo);
        else             return y_t'(s);
    endfunction

endpackage

// File: rtl/poly9_powers.sv
module poly9_powers
    import poly9_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  x_t     x_in,
    output pw_s1_t p1,
    output pw_s2_t p2,
    output pw_s3_t p3
);

    // Stage 1: the sample and its square.
    always_ff @(posedge clk) begin
        if (rst) begin
            p1 <= '0;
        end else begin
            p1.x  <= x_in;
            p1.sq <= pw_from_x(x_in);
        end
    end

    // Stage 2: cube and fourth power from stage-1 values.
    always_ff @(posedge clk) begin
        if (rst) begin
            p2 <= '0;
        end else begin
            p2.sq   <= p1.sq;
            p2.cube <= pw_mul_x(p1.sq, p1.x);
            p2.quad <= pw_mul(p1.sq, p1.sq);
        end
    end

    // Stage 3: hold cube and fourth power for the last multiply stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            p3 <= '0;
        end else begin
            p3.cube <= p2.cube;
            p3.quad <= p2.quad;
        end
    end

endmodule

// File: rtl/poly9_terms.sv
module poly9_terms
    import poly9_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  x_t                        x_in,
    input  logic [(NCOEF-1)*CW-1:0]   coef_hi,
    input  pw_s1_t                    p1,
    input  pw_s2_t                    p2,
    input  pw_s3_t                    p3,
    output term_bus_t                 terms
);

    term_t ax [1:NCOEF-1];

    // Stage 1: every coefficient times x, in parallel.
    always_ff @(posedge clk) begin
        for (int i = 1; i < NCOEF; i++) begin
            if (rst) ax[i] <= '0;
            else     ax[i] <= tm_coef_x(coef_t'(coef_hi[(i-1)*CW +: CW]), x_in);
        end
    end

    // Stage 2
    term_t d2_1, d2_2, d2_3, w4, w5, w6, w7, h8, h9;
    always_ff @(posedge clk) begin
        if (rst) begin
            d2_1 <= '0; d2_2 <= '0; d2_3 <= '0;
            w4 <= '0; w5 <= '0; w6 <= '0; w7 <= '0; h8 <= '0; h9 <= '0;
        end else begin
            d2_1 <= ax[1];
            d2_2 <= tm_x(ax[2], p1.x);
            d2_3 <= tm_pow(ax[3], p1.sq);
            w4   <= tm_x(ax[4], p1.x);
            w5   <= tm_x(ax[5], p1.x);
            w6   <= tm_pow(ax[6], p1.sq);
            w7   <= tm_pow(ax[7], p1.sq);
            h8   <= ax[8];
            h9   <= ax[9];
        end
    end

    // Stage 3
    term_t d3_1, d3_2, d3_3, d3_4, d3_5, d3_6, d3_7, v8, v9;
    always_ff @(posedge clk) begin
        if (rst) begin
            d3_1 <= '0; d3_2 <= '0; d3_3 <= '0; d3_4 <= '0;
            d3_5 <= '0; d3_6 <= '0; d3_7 <= '0; v8 <= '0; v9 <= '0;
        end else begin
            d3_1 <= d2_1;
            d3_2 <= d2_2;
            d3_3 <= d2_3;
            d3_4 <= tm_pow(w4, p2.sq);
            d3_5 <= tm_pow(w5, p2.cube);
            d3_6 <= tm_pow(w6, p2.cube);
            d3_7 <= tm_pow(w7, p2.quad);
            v8   <= tm_pow(h8, p2.quad);
            v9   <= tm_pow(h9, p2.quad);
        end
    end

    // Stage 4: last two multiplies; the rest are aligned by one more register.
    always_ff @(posedge clk) begin
        if (rst) begin
            terms <= '0;
        end else begin
            terms[1] <= d3_1;
            terms[2] <= d3_2;
            terms[3] <= d3_3;
            terms[4] <= d3_4;
            terms[5] <= d3_5;
            terms[6] <= d3_6;
            terms[7] <= d3_7;
            terms[8] <= tm_pow(v8, p3.cube);
            terms[9] <= tm_pow(v9, p3.quad);
        end
    end

endmodule

// File: rtl/poly9_sum.sv
module poly9_sum
    import poly9_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  coef_t     a0,
    input  term_bus_t terms,
    output y_t        y
);

    acc_t acc;

    always_comb begin
        acc = SW'(a0);
        for (int i = 1; i < NCOEF; i++) begin
            acc = acc + SW'($signed(terms[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) y <= '0;
        else     y <= sat_y(acc);
    end

endmodule

// File: rtl/poly9_eval.sv
module poly9_eval
    import poly9_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [XW-1:0]         x_in,
    input  logic [NCOEF*CW-1:0]   coef,
    output logic                  out_valid,
    output logic [YW-1:0]         y_out
);

    pw_s1_t    p1;
    pw_s2_t    p2;
    pw_s3_t    p3;
    term_bus_t terms;
    y_t        y_s5;
    logic [LAT-1:0] vld;

    poly9_powers u_powers (
        .clk  (clk),
        .rst  (rst),
        .x_in (x_t'(x_in)),
        .p1   (p1),
        .p2   (p2),
        .p3   (p3)
    );

    poly9_terms u_terms (
        .clk     (clk),
        .rst     (rst),
        .x_in    (x_t'(x_in)),
        .coef_hi (coef[NCOEF*CW-1:CW]),
        .p1      (p1),
        .p2      (p2),
        .p3      (p3),
        .terms   (terms)
    );

    poly9_sum u_sum (
        .clk   (clk),
        .rst   (rst),
        .a0    (coef_t'(coef[CW-1:0])),
        .terms (terms),
        .y     (y_s5)
    );

    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= {vld[LAT-2:0], in_valid};
    end

    assign out_valid = vld[LAT-1];
    assign y_out     = y_s5;

endmodule

// File: rtl/poly9_eval_chk.sv
module poly9_eval_chk
    import poly9_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [XW-1:0]         x_in,
    input logic [NCOEF*CW-1:0]   coef,
    input logic                  out_valid,
    input logic [YW-1:0]         y_out
);

    logic [LAT:1]                vin_d;
    logic [XW-1:0]               x_d   [1:LAT];
    logic [(NCOEF-1)*CW-1:0]     chi_d [1:LAT];
    logic [CW-1:0]               a0_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            vin_d <= '0;
            a0_d  <= '0;
            for (int i = 1; i <= LAT; i++) begin
                x_d[i]   <= '0;
                chi_d[i] <= '0;
            end
        end else begin
            vin_d    <= {vin_d[LAT-1:1], in_valid};
            a0_d     <= coef[CW-1:0];
            x_d[1]   <= x_in;
            chi_d[1] <= coef[NCOEF*CW-1:CW];
            for (int i = 2; i <= LAT; i++) begin
                x_d[i]   <= x_d[i-1];
                chi_d[i] <= chi_d[i-1];
            end
        end
    end

    acc_t alt;
    always_comb begin
        alt = SW'($signed(a0_d));
        for (int i = 1; i < NCOEF; i++) begin
            if (i % 2 == 1) alt = alt - SW'($signed(chi_d[LAT][(i-1)*CW +: CW]));
            else            alt = alt + SW'($signed(chi_d[LAT][(i-1)*CW +: CW]));
        end
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == vin_d[LAT]);

    a_r5_zero_x: assert property (@(posedge clk) disable iff (rst)
        (out_valid && x_d[LAT] == '0) |-> (y_out == YW'($signed(a0_d))));

    a_r6_neg_one: assert property (@(posedge clk) disable iff (rst)
        (out_valid && x_d[LAT] == {1'b1, {(XW-1){1'b0}}}) |-> (y_out == sat_y(alt)));

    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && y_out == '0));

endmodule

bind poly9_eval poly9_eval_chk u_chk (.*);

// File: tb/poly9_eval_bench.sv
module poly9_eval_bench;
    import poly9_pkg::*;

    localparam int TOL = 64;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [XW-1:0]        x_in = '0;
    logic [NCOEF*CW-1:0]  coef = '0;
    logic                 out_valid;
    logic [YW-1:0]        y_out;

    poly9_eval u_poly9_eval (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .x_in      (x_in),
        .coef      (coef),
        .out_valid (out_valid),
        .y_out     (y_out)
    );

    always #2 clk = ~clk;

    typedef struct {
        real   expv;
        real   tol;
        longint cyc;
        string req;
    } exp_t;

    exp_t   sb[$];
    longint cyc = 0;
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic real ref_y(logic [NCOEF*CW-1:0] c, logic [XW-1:0] x);
        real xr, pw, acc, r;
        xr  = $itor($signed(x)) / (2.0 ** XF);
        pw  = 1.0;
        acc = 0.0;
        for (int i = 0; i < NCOEF; i++) begin
            acc = acc + ($itor($signed(c[i*CW +: CW])) / (2.0 ** CF)) * pw;
            pw  = pw * xr;
        end
        r = acc * (2.0 ** CF);
        if (r > 32767.0)  r = 32767.0;
        if (r < -32768.0) r = -32768.0;
        return r;
    endfunction

    task automatic check(bit ok, string req, real act, real expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0.3f expected %0.3f", req, act, expv);
        end
    endtask

    task automatic send(int xv, real tol, string req);
        @(posedge clk); #1;
        in_valid = 1'b1;
        x_in     = XW'(xv);
        sb.push_back('{ref_y(coef, XW'(xv)), tol, cyc, req});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
        end
    endtask

    task automatic set_coef(int sel);
        for (int i = 0; i < NCOEF; i++) begin
            case (sel)
                0: coef[i*CW +: CW] = CW'(((i * 2731) % 8192) - 4096);
                1: coef[i*CW +: CW] = CW'(((i * 12345 + 777) % 65536) - 32768);
                2: coef[i*CW +: CW] = CW'((i % 2 == 1) ? -1000 * (i + 1) : 1000 * (i + 1));
                3: coef[i*CW +: CW] = CW'(32767);
                default: coef[i*CW +: CW] = CW'(-32768);
            endcase
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: pops the scoreboard whenever a result appears.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3 unexpected out_valid", 1.0, 0.0);
            end else begin
                exp_t e;
                real  act, diff;
                e    = sb.pop_front();
                act  = $itor($signed(y_out));
                diff = act - e.expv;
                if (diff < 0.0) diff = -diff;
                check(diff <= e.tol, e.req, act, e.expv);
                check(cyc - e.cyc == LAT, "R2 latency", $itor(cyc - e.cyc), $itor(LAT));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 reset valid", $itor(out_valid), 0.0);
        check(y_out == '0, "R7 reset data", $itor($signed(y_out)), 0.0);

        // R1/R3: full sweep, back to back, moderate coefficients
        set_coef(0);
        for (int v = -128; v < 128; v++) send(v, TOL, "R1 sweep A");
        idle(LAT + 3);

        // R1/R3: full sweep with gaps, large coefficients
        set_coef(1);
        for (int v = -128; v < 128; v++) begin
            if ((v + 128) % 3 == 1) idle(1);
            send(v, TOL, "R1 sweep B gaps");
        end
        idle(LAT + 3);

        // R5 / R6 exact cases under two coefficient sets
        send(0, 0.0, "R5 x zero set B");
        send(-128, 0.0, "R6 x minus one set B");
        idle(LAT + 3);
        set_coef(2);
        send(0, 0.0, "R5 x zero set C");
        send(-128, 0.0, "R6 x minus one set C");
        send(64, TOL, "R1 half set C");
        idle(LAT + 3);

        // R4 saturation both ways
        set_coef(3);
        send(127, 0.0, "R4 positive clamp");
        idle(LAT + 3);
        set_coef(4);
        send(127, 0.0, "R4 negative clamp");
        send(-128, 0.0, "R6 x minus one full scale");
        idle(LAT + 3);

        // R7: reset with samples in flight
        set_coef(2);
        send(10, TOL, "R7 pre");
        send(20, TOL, "R7 pre");
        send(30, TOL, "R7 pre");
        @(negedge clk); #1;
        rst = 1'b1;
        in_valid = 1'b0;
        sb.delete();
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        idle(LAT + 3);
        @(negedge clk);
        check(out_valid == 1'b0 && sb.size() == 0, "R7 flush", $itor(out_valid), 0.0);
        send(0, 0.0, "R5 after reset");
        idle(LAT + 3);

        check(sb.size() == 0, "R3 one result per input", $itor(sb.size()), 0.0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule